// File: doc/BRIEF.md
# Auto-Negotiation Code Word Arbiter

This block sits after the fast-link-pulse burst decoder of a 10/100 copper port. It takes decoded 16-bit link code words, one per handshake, and qualifies them. A word counts only after three identical words arrive in a row, and the acknowledge bit is masked in every comparison. The first qualified word is kept as the partner's ability word. A second qualified run then triggers mode resolution: the local and partner ability bits are combined and the highest shared mode is chosen.

Parallel detection works beside this path. A pulse on the normal-link-pulse or the 100 Mb/s idle detect input ends arbitration at once, at the detected speed in half duplex, and replaces any negotiated result. While the block is hunting for code words it presents the local advertisement word on a valid-qualified output to the pulse encoder. A restart or link-loss event returns it to the hunt. Fiber mode, or clearing the enable, parks the block.

Code words use a valid/ready stream. A transfer happens on a rising edge only when `cw_valid` and `cw_ready` are both high. The sender must hold `cw_data` stable while `cw_valid` is high and `cw_ready` is low. `cw_ready` is high only while the block is hunting, and it never depends on `cw_valid`.

Top module: `an_arbiter`

## Requirements
- R1: After reset, with negotiation enabled and fiber mode off, `an_done`, `speed100`, `full_duplex` and `no_common` are 0, `partner_word` is 0, and `cw_ready` and `adv_valid` are 1.
- R2: When three consecutive transferred words are equal, the third word is loaded into `partner_word` at the edge of its transfer.
- R3: Bit 14 (acknowledge) is excluded from the match comparison, so words that differ only in bit 14 count as identical.
- R4: A transferred word that differs from the previous one (outside bit 14) restarts the count at one. A run of four identical words qualifies once, and the fourth word starts a new run.
- R5: After the first qualified run, a second qualified run of three identical words is required. At the edge of its third transfer, `an_done` rises and the resolved mode appears. `partner_word` keeps the first run's word.
- R6: The resolution uses ability bits 8 (100 full), 7 (100 half), 6 (10 full) and 5 (10 half) of the bitwise AND of the local and partner words. It picks in the order 100 full, 100 half, 10 full, 10 half. `speed100` is 1 for 100 Mb/s and `full_duplex` is 1 for full duplex.
- R7: If no ability bit is shared, `an_done` rises with `no_common` at 1 and `speed100`/`full_duplex` at 0.
- R8: Any hunting or done state (not parked, no restart or link loss) can receive a detect pulse. On `idle100_det` the block goes done at 100 Mb/s half duplex on the next edge. On `nlp_det` it goes done at 10 Mb/s half duplex. The idle detect wins if both are high. This overrides a negotiated result.
- R9: A `restart` or `link_loss` pulse clears `an_done`, the mode outputs, `partner_word` and the match count, and returns the block to hunting.
- R10: While `fiber_mode` is 1 or `an_enable` is 0, the block is parked: `cw_ready`, `adv_valid`, `an_done` and `partner_word` read 0. When it is released, it hunts again one cycle later.
- R11: `adv_valid` is high exactly while hunting. `adv_word` then equals `local_adv`; otherwise it is 0.
- R12: In the done state `cw_ready` is 0, so offered words are not taken and `partner_word` is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| an_enable | input | 1 | Negotiation enable |
| fiber_mode | input | 1 | Fiber operation; parks negotiation |
| restart | input | 1 | Restart pulse |
| link_loss | input | 1 | Link-loss pulse |
| nlp_det | input | 1 | 10 Mb/s normal link pulse detected |
| idle100_det | input | 1 | 100 Mb/s idle detected |
| local_adv | input | 16 | Local advertisement word |
| cw_valid | input | 1 | Code word valid |
| cw_ready | output | 1 | Code word ready |
| cw_data | input | 16 | Decoded code word |
| adv_valid | output | 1 | Advertisement being sent |
| adv_word | output | 16 | Advertisement word to the encoder |
| an_done | output | 1 | Arbitration complete |
| speed100 | output | 1 | Resolved speed is 100 Mb/s |
| full_duplex | output | 1 | Resolved duplex is full |
| no_common | output | 1 | No shared ability |
| partner_word | output | 16 | Stored partner ability word |

## Verification
The hardest state to reach is a match count left partly filled by a broken run. Here the next qualifying run has to start from the word that broke the old one. The stimulus sends two equal words, one different word, then equal words again, and checks that the partner word loads on exactly the right transfer. The acknowledge-bit mask is reached by toggling bit 14 inside a run. The override of a finished negotiation is reached by pulsing a detect input after a full six-word exchange.

// File: rtl/an_pkg.sv
package an_pkg;
  localparam int CW_W       = 16;
  localparam int ACK_POS    = 14;
  localparam int AB_LO      = 5;   // 10 half
  localparam int AB_N       = 4;   // bits 5..8
  localparam int MATCH_RUN  = 3;

  typedef enum logic [1:0] {
    ST_PARK  = 2'd0,
    ST_HUNT1 = 2'd1,
    ST_HUNT2 = 2'd2,
    ST_DONE  = 2'd3
  } an_state_e;

  typedef struct packed {
    logic spd100;
    logic fdx;
    logic none;
  } an_mode_t;
endpackage

// File: rtl/an_match_qual.sv
module an_match_qual #(
  parameter int W         = 16,
  parameter int ACK       = 14,
  parameter int MATCH_CNT = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         fire,
  input  logic [W-1:0] word,
  output logic         accept
);
  localparam int CNT_W = $clog2(MATCH_CNT + 1);
  localparam logic [W-1:0] CMP_MASK = ~(W'(1) << ACK);

  logic [W-1:0]     last_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_next;
  logic             same;

  always_comb begin
    same     = (cnt_q != '0) && ((word & CMP_MASK) == (last_q & CMP_MASK));
    cnt_next = same ? cnt_q + 1'b1 : CNT_W'(1);
    accept   = fire && (cnt_next == CNT_W'(MATCH_CNT));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      cnt_q  <= '0;
    end else if (clr) begin
      cnt_q  <= '0;
    end else if (fire) begin
      last_q <= word;
      cnt_q  <= accept ? '0 : cnt_next;
    end
  end
endmodule

// File: rtl/an_mode_resolve.sv
module an_mode_resolve
  import an_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0] local_ab,
  input  logic [N-1:0] partner_ab,
  output an_mode_t     mode
);
  logic [N-1:0] common;
  logic         found;

  always_comb begin
    common = local_ab & partner_ab;
    mode   = '{spd100: 1'b0, fdx: 1'b0, none: 1'b1};
    found  = 1'b0;
    // index N-1 is 100 full, down to index 0 for 10 half
    for (int i = N - 1; i >= 0; i--) begin
      if (!found && common[i]) begin
        found       = 1'b1;
        mode.none   = 1'b0;
        mode.spd100 = (i >= N / 2);
        mode.fdx    = (i % 2) == 1;
      end
    end
  end
endmodule

// File: rtl/an_par_detect.sv
module an_par_detect (
  input  logic nlp_det,
  input  logic idle100_det,
  output logic hit,
  output logic hit_100
);
  always_comb begin
    hit     = nlp_det || idle100_det;
    hit_100 = idle100_det;
  end
endmodule

// File: rtl/an_arbiter.sv
module an_arbiter
  import an_pkg::*;
#(
  parameter int W         = CW_W,
  parameter int ACK       = ACK_POS,
  parameter int MATCH_CNT = MATCH_RUN
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         an_enable,
  input  logic         fiber_mode,
  input  logic         restart,
  input  logic         link_loss,
  input  logic         nlp_det,
  input  logic         idle100_det,
  input  logic [W-1:0] local_adv,
  input  logic         cw_valid,
  output logic         cw_ready,
  input  logic [W-1:0] cw_data,
  output logic         adv_valid,
  output logic [W-1:0] adv_word,
  output logic         an_done,
  output logic         speed100,
  output logic         full_duplex,
  output logic         no_common,
  output logic [W-1:0] partner_word
);
  localparam int AB_HI = AB_LO + AB_N - 1;

  an_state_e    state_q;
  an_mode_t     mode_q;
  an_mode_t     mode_res;
  logic [W-1:0] partner_q;
  logic         done_q;
  logic         active, rst_evt, hunting, fire, accept, pd_hit, pd_100;

  assign active  = an_enable && !fiber_mode;
  assign rst_evt = restart || link_loss;
  assign hunting = (state_q == ST_HUNT1) || (state_q == ST_HUNT2);
  assign fire    = cw_valid && hunting;

  an_match_qual #(.W(W), .ACK(ACK), .MATCH_CNT(MATCH_CNT)) u_qual (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (rst_evt || !active),
    .fire   (fire),
    .word   (cw_data),
    .accept (accept)
  );

  an_mode_resolve #(.N(AB_N)) u_res (
    .local_ab   (local_adv[AB_HI:AB_LO]),
    .partner_ab (partner_q[AB_HI:AB_LO]),
    .mode       (mode_res)
  );

  an_par_detect u_pd (
    .nlp_det     (nlp_det),
    .idle100_det (idle100_det),
    .hit         (pd_hit),
    .hit_100     (pd_100)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_HUNT1;
      partner_q <= '0;
      mode_q    <= '0;
      done_q    <= 1'b0;
    end else if (!active) begin
      state_q   <= ST_PARK;
      partner_q <= '0;
      mode_q    <= '0;
      done_q    <= 1'b0;
    end else if (rst_evt) begin
      state_q   <= ST_HUNT1;
      partner_q <= '0;
      mode_q    <= '0;
      done_q    <= 1'b0;
    end else if (pd_hit && state_q != ST_PARK) begin
      state_q   <= ST_DONE;
      done_q    <= 1'b1;
      mode_q    <= '{spd100: pd_100, fdx: 1'b0, none: 1'b0};
    end else begin
      unique case (state_q)
        ST_PARK:  state_q <= ST_HUNT1;
        ST_HUNT1: if (accept) begin
          partner_q <= cw_data;
          state_q   <= ST_HUNT2;
        end
        ST_HUNT2: if (accept) begin
          state_q <= ST_DONE;
          done_q  <= 1'b1;
          mode_q  <= mode_res;
        end
        ST_DONE:  state_q <= ST_DONE;
        default:  state_q <= ST_PARK;
      endcase
    end
  end

  assign cw_ready     = hunting;
  assign adv_valid    = hunting;
  assign adv_word     = hunting ? local_adv : '0;
  assign an_done      = done_q;
  assign speed100     = mode_q.spd100;
  assign full_duplex  = mode_q.fdx;
  assign no_common    = mode_q.none;
  assign partner_word = partner_q;
endmodule

// File: rtl/an_arbiter_chk.sv
module an_arbiter_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         an_enable,
  input logic         fiber_mode,
  input logic         restart,
  input logic         link_loss,
  input logic         idle100_det,
  input logic         cw_ready,
  input logic         adv_valid,
  input logic         an_done,
  input logic         speed100,
  input logic         full_duplex,
  input logic         no_common,
  input logic [W-1:0] partner_word
);
  p_park_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fiber_mode || !an_enable) |=> (!cw_ready && !adv_valid && !an_done));

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (an_enable && !fiber_mode && (restart || link_loss))
      |=> (!an_done && partner_word == '0 && cw_ready));

  p_pd_100_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (an_enable && !fiber_mode && !restart && !link_loss && idle100_det)
      |=> (an_done && speed100 && !full_duplex));

  p_none_r7: assert property (@(posedge clk) disable iff (!rst_n)
    no_common |-> (an_done && !speed100 && !full_duplex));

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (an_done && an_enable && !fiber_mode && !restart && !link_loss)
      |=> $stable(partner_word));

  p_noready_r12: assert property (@(posedge clk) disable iff (!rst_n)
    an_done |-> !cw_ready);
endmodule

bind an_arbiter an_arbiter_chk #(.W(W)) u_chk (.*);

// File: tb/an_arbiter_bench.sv
module an_arbiter_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] ACK = 16'h4000;
  // local[34:19] partner[18:3] expected {spd100, fdx, none}[2:0]
  localparam logic [34:0] VEC [8] = '{
    {16'h01E1, 16'h01E1, 3'b110},
    {16'h00E1, 16'h01E1, 3'b100},
    {16'h0061, 16'h01E1, 3'b010},
    {16'h0021, 16'h01E1, 3'b000},
    {16'h01E1, 16'h00A1, 3'b100},
    {16'h0141, 16'h00A1, 3'b001},
    {16'h0161, 16'h0061, 3'b010},
    {16'h0121, 16'h01A1, 3'b110}
  };

  logic clk = 0, rst_n = 0;
  logic an_enable = 1, fiber_mode = 0, restart = 0, link_loss = 0;
  logic nlp_det = 0, idle100_det = 0, cw_valid = 0;
  logic [15:0] local_adv = 16'h01E1, cw_data = 0;
  logic cw_ready, adv_valid, an_done, speed100, full_duplex, no_common;
  logic [15:0] adv_word, partner_word;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  an_arbiter u_an_arbiter (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(logic [15:0] w);
    cw_valid = 1; cw_data = w;
    @(negedge clk);
    cw_valid = 0;
  endtask

  task automatic pulse_restart();
    restart = 1; @(negedge clk); restart = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 done/mode", {an_done, speed100, full_duplex, no_common}, 0);
    chk("R1 partner", partner_word, 0);
    chk("R1 ready/adv", {cw_ready, adv_valid}, 2'b11);
    chk("R11 adv_word", adv_word, 16'h01E1);

    // R2 R5 R6 R7: table walk
    foreach (VEC[i]) begin
      pulse_restart();
      local_adv = VEC[i][34:19];
      for (int k = 0; k < 3; k++) send(VEC[i][18:3]);
      chk("R2 partner after first run", partner_word, VEC[i][18:3]);
      chk("R5 not done after one run", an_done, 0);
      for (int k = 0; k < 3; k++) send(VEC[i][18:3] | ACK);
      chk("R5 done after second run", an_done, 1);
      chk("R6/R7 mode", {speed100, full_duplex, no_common}, VEC[i][2:0]);
      chk("R5 partner keeps first word", partner_word, VEC[i][18:3]);
    end

    // R12: done ignores words
    chk("R12 ready low in done", cw_ready, 0);
    chk("R11 adv off in done", {adv_valid, adv_word}, 0);
    for (int k = 0; k < 3; k++) send(16'h0021);
    chk("R12 partner held", partner_word, 16'h01A1);

    // R8: override a negotiated 100 full result with NLP
    nlp_det = 1; @(negedge clk); nlp_det = 0;
    chk("R8 nlp override", {an_done, speed100, full_duplex, no_common}, 4'b1000);

    // R9: link loss clears
    link_loss = 1; @(negedge clk); link_loss = 0;
    chk("R9 link loss clears", {an_done, speed100, full_duplex, cw_ready}, 4'b0001);
    chk("R9 partner cleared", partner_word, 0);

    // R8: both detects -> 100 half
    nlp_det = 1; idle100_det = 1; @(negedge clk); nlp_det = 0; idle100_det = 0;
    chk("R8 idle wins", {an_done, speed100, full_duplex}, 3'b110);

    // R3: ack bit masked within a run
    pulse_restart();
    send(16'h01E1); send(16'h01E1 | ACK); send(16'h01E1);
    chk("R3 ack masked", partner_word, 16'h01E1);

    // R4: broken run restarts count
    pulse_restart();
    send(16'h01E1); send(16'h01E1); send(16'h0061); send(16'h01E1); send(16'h01E1);
    chk("R4 no accept after break", partner_word, 0);
    send(16'h01E1);
    chk("R4 accept on third after break", partner_word, 16'h01E1);

    // R4: four identical -> fourth starts run two
    pulse_restart();
    local_adv = 16'h01E1;
    for (int k = 0; k < 4; k++) send(16'h0041);
    chk("R4 fourth word not done", an_done, 0);
    send(16'h0041);
    chk("R4 still one short", an_done, 0);
    send(16'h0041);
    chk("R4 second run completes", {an_done, speed100, full_duplex}, 3'b101);

    // R10: fiber parks
    fiber_mode = 1; @(negedge clk);
    chk("R10 parked", {cw_ready, adv_valid, an_done}, 0);
    chk("R10 partner cleared", partner_word, 0);
    for (int k = 0; k < 3; k++) send(16'h01E1);
    chk("R10 words ignored", partner_word, 0);
    fiber_mode = 0; @(negedge clk);
    chk("R10 hunting after release", {cw_ready, adv_valid}, 2'b11);

    // R10: disable parks too
    an_enable = 0; @(negedge clk);
    chk("R10 disable parks", {cw_ready, an_done}, 0);
    an_enable = 1; @(negedge clk);
    chk("R10 resume after enable", cw_ready, 1);

    finish_run();
  end
endmodule